// File: doc/BRIEF.md
# Interrupt Claim and Completion Controller

This block arbitrates a set of level-type interrupt lines for a single receiving hart. Each line passes through a small gateway. The gateway raises a pending flag for the source and then blocks that line until software has finished servicing it. Software programs a priority for each source, an enable bit for each source and one threshold. The block drives one interrupt output toward the hart for as long as some pending, enabled source has a priority strictly above the threshold.

Software uses one register for both halves of a service. Reading it claims the best eligible source: the read returns the source number, clears that source's pending flag and marks it in service. Writing a source number to the same register ends its service. That completion is taken only when the named source is currently enabled. It is never compared with the number that was last claimed. A source that is disabled while in service therefore stays blocked until a later completion arrives while it is enabled.

Register addresses: 0 is claim/complete, 1 is threshold, 2 is the enable mask, and 32+i holds the priority of source i.

Top module: `irqc_top`

## Requirements
- R1: After reset the interrupt output is low. A claim read returns 0, and the threshold (address 1), the enable mask (address 2) and every priority (address 32+i) read back as 0.
- R2: A source whose line is high while it is neither pending nor in service becomes pending one clock later. A source is never pending and in service at the same time.
- R3: The interrupt output is high exactly when some source is pending, has its enable bit set (bit i of address 2 for source i) and has a priority strictly greater than the threshold (low 3 bits of address 1).
- R4: A claim read (read of address 0) returns the eligible source with the highest priority. Among equal priorities it returns the lowest source number. It returns 0 when no source is eligible.
- R5: A claim read that returns source k clears k's pending flag and sets k in service on the same clock edge. A claim read that returns 0 changes no state.
- R6: Writing k (1..8) to address 0 while source k is enabled ends k's service, even if k is not the source claimed last. If k's line is still high, k becomes pending again one clock after that.
- R7: Writing k to address 0 while k's enable bit is clear is dropped. Source k stays in service, its line is ignored and it never reaches the output, until an accepted completion for k.
- R8: A completion write with value 0, or with a value greater than the number of sources, changes no state. This holds even when the low bits of the value name a valid source.
- R9: Writes to the threshold, enable or priority registers never clear a pending flag and never change an in-service flag.
- R10: A source with priority 0 is never signalled and never returned by a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcIrq | input | NUM_SRC | Level interrupt lines; bit i is source i (1-based) |
| regRe | input | 1 | Register read strobe |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr while regRe is high |
| targetIrq | output | 1 | Interrupt request to the hart |

## Verification
The assertions assume the register port performs at most one access per cycle. A read and a write therefore never target address 0 in the same cycle, and a configuration write never coincides with a claim or a completion. The assertions also assume that regAddr and regWdata are stable whenever a strobe is high. The bench drives each access as one strobe held for exactly one clock, changes inputs only on the falling edge, and keeps each source line at a constant level across every access that could claim or complete that source. A behavioural model of pending and in-service state, advanced on every rising edge, gives the expected output level and claim value for each cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W = 32;
  localparam int ID_W = 8;
  localparam int ADDR_CLAIM = 0;
  localparam int ADDR_THR = 1;
  localparam int ADDR_EN = 2;
  localparam int ADDR_PRIO_BASE = 32;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_CLAIM = 3'd1,
    RD_THR   = 3'd2,
    RD_EN    = 3'd3,
    RD_PRIO  = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic            claim;
    logic            complete;
    logic [ID_W-1:0] cplId;
    logic            thrWe;
    logic            enWe;
    logic            prioWe;
    logic [ID_W-1:0] regId;
    rdSel_e          rdSel;
    logic [REG_W-1:0] wdata;
  } ctrlStb_t;
endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic claimHit,
  input  logic cplHit,
  output logic pend,
  output logic svc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      svc  <= 1'b0;
    end else begin
      if (claimHit) begin
        pend <= 1'b0;
        svc  <= 1'b1;
      end else if (line && !pend && !svc) begin
        pend <= 1'b1;
      end
      if (cplHit) svc <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 6
) (
  input  logic              regRe,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output ctrlStb_t          stb
);
  int addrInt;
  int prioIdx;
  logic prioHit;
  logic idOk;

  always_comb begin
    addrInt = int'(regAddr);
    prioIdx = addrInt - ADDR_PRIO_BASE;
    prioHit = (prioIdx >= 1) && (prioIdx <= NUM_SRC);
    idOk = (regWdata != '0) && (regWdata <= REG_W'(NUM_SRC));

    stb = '0;
    stb.wdata = regWdata;
    stb.cplId = regWdata[ID_W-1:0];
    stb.regId = ID_W'(prioIdx);

    if (regRe) begin
      if (addrInt == ADDR_CLAIM) begin
        stb.claim = 1'b1;
        stb.rdSel = RD_CLAIM;
      end else if (addrInt == ADDR_THR) begin
        stb.rdSel = RD_THR;
      end else if (addrInt == ADDR_EN) begin
        stb.rdSel = RD_EN;
      end else if (prioHit) begin
        stb.rdSel = RD_PRIO;
      end
    end

    if (regWe) begin
      if (addrInt == ADDR_CLAIM) stb.complete = idOk;
      else if (addrInt == ADDR_THR) stb.thrWe = 1'b1;
      else if (addrInt == ADDR_EN) stb.enWe = 1'b1;
      else if (prioHit) stb.prioWe = 1'b1;
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC:1]   srcIrq,
  input  ctrlStb_t           stb,
  output logic [REG_W-1:0]   rdata,
  output logic               targetIrq,
  output logic [NUM_SRC:1]   pendVec,
  output logic [NUM_SRC:1]   svcVec,
  output logic [NUM_SRC:1]   enVec
);
  logic [PRIO_W-1:0] prio [NUM_SRC:1];
  logic [PRIO_W-1:0] thr;
  logic [NUM_SRC:1]  eligible;
  logic [ID_W-1:0]   bestId;
  logic [PRIO_W-1:0] bestPrio;
  logic              unusedBits;

  assign unusedBits = ^stb.wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr   <= '0;
      enVec <= '0;
    end else begin
      if (stb.thrWe) thr <= stb.wdata[PRIO_W-1:0];
      if (stb.enWe) enVec <= stb.wdata[NUM_SRC:1];
    end
  end

  for (genvar g = 1; g <= NUM_SRC; g++) begin : gSrc
    logic claimHit;
    logic cplHit;

    assign claimHit = stb.claim && (bestId == ID_W'(g));
    assign cplHit = stb.complete && (stb.cplId == ID_W'(g)) && enVec[g];

    always_ff @(posedge clk) begin
      if (rst) prio[g] <= '0;
      else if (stb.prioWe && stb.regId == ID_W'(g)) prio[g] <= stb.wdata[PRIO_W-1:0];
    end

    irqc_gateway u_gw (
      .clk      (clk),
      .rst      (rst),
      .line     (srcIrq[g]),
      .claimHit (claimHit),
      .cplHit   (cplHit),
      .pend     (pendVec[g]),
      .svc      (svcVec[g])
    );

    assign eligible[g] = pendVec[g] && enVec[g] && (prio[g] > thr);
  end

  always_comb begin
    bestId = '0;
    bestPrio = thr;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (eligible[i] && prio[i] > bestPrio) begin
        bestId = ID_W'(i);
        bestPrio = prio[i];
      end
    end
  end

  assign targetIrq = |eligible;

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      RD_CLAIM: rdata = REG_W'(bestId);
      RD_THR:   rdata = REG_W'(thr);
      RD_EN:    rdata = REG_W'({enVec, 1'b0});
      RD_PRIO: begin
        for (int i = 1; i <= NUM_SRC; i++)
          if (stb.regId == ID_W'(i)) rdata = REG_W'(prio[i]);
      end
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC:1]  srcIrq,
  input  logic              regRe,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              targetIrq
);
  ctrlStb_t stb;
  logic [NUM_SRC:1] pendVec;
  logic [NUM_SRC:1] svcVec;
  logic [NUM_SRC:1] enVec;

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .regRe    (regRe),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .stb      (stb)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .srcIrq    (srcIrq),
    .stb       (stb),
    .rdata     (regRdata),
    .targetIrq (targetIrq),
    .pendVec   (pendVec),
    .svcVec    (svcVec),
    .enVec     (enVec)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              regRe,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              targetIrq,
  input logic [NUM_SRC:1]  pendVec,
  input logic [NUM_SRC:1]  svcVec,
  input logic [NUM_SRC:1]  enVec
);
  logic claimRd, cplWr, cfgWr, idInRange, enOfId;
  logic capValid;
  logic [31:0] capId;
  logic [NUM_SRC:0] pend0, svc0, en0;

  assign claimRd = regRe && (regAddr == '0);
  assign cplWr = regWe && (regAddr == '0);
  assign cfgWr = regWe && (regAddr != '0);
  assign pend0 = {pendVec, 1'b0};
  assign svc0 = {svcVec, 1'b0};
  assign en0 = {enVec, 1'b0};
  assign idInRange = (regWdata != 0) && (regWdata <= NUM_SRC);
  assign enOfId = idInRange && ((en0 >> regWdata[7:0]) & 1) != 0;

  always_ff @(posedge clk) begin
    if (rst) begin
      capValid <= 1'b0;
      capId <= '0;
    end else begin
      capValid <= claimRd && (regRdata != 0);
      capId <= regRdata;
    end
  end

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    (pendVec & svcVec) == '0);

  assert_claim_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (claimRd && !targetIrq) |-> regRdata == 0);

  assert_claim_found_R4: assert property (@(posedge clk) disable iff (rst)
    (claimRd && targetIrq) |-> (regRdata != 0 && regRdata <= NUM_SRC));

  assert_claim_marks_R5: assert property (@(posedge clk) disable iff (rst)
    capValid |-> (((svc0 >> capId[7:0]) & 1) != 0 && ((pend0 >> capId[7:0]) & 1) == 0));

  assert_drop_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (cplWr && idInRange && !enOfId) |=> $stable(svcVec));

  assert_bad_id_R8: assert property (@(posedge clk) disable iff (rst)
    (cplWr && !idInRange) |=> $stable(svcVec));

  assert_cfg_keep_R9: assert property (@(posedge clk) disable iff (rst)
    cfgWr |=> ($stable(svcVec) && ((pendVec & $past(pendVec)) == $past(pendVec))));
endmodule

bind irqc_top irqc_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regRe     (regRe),
  .regWe     (regWe),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .targetIrq (targetIrq),
  .pendVec   (pendVec),
  .svcVec    (svcVec),
  .enVec     (enVec)
);

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  localparam int N = 8;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N:1] srcIrq = '0;
  logic regRe = 1'b0;
  logic regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic targetIrq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit mPend [1:N];
  bit mSvc [1:N];
  bit mEn [1:N];
  int mPrio [1:N];
  int mThr;

  always #2 clk = ~clk;

  irqc_top #(.NUM_SRC(N), .PRIO_W(3), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .srcIrq(srcIrq), .regRe(regRe), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .targetIrq(targetIrq)
  );

  function automatic int mBest();
    int best = 0;
    int bp = mThr;
    for (int i = 1; i <= N; i++)
      if (mPend[i] && mEn[i] && mPrio[i] > bp) begin best = i; bp = mPrio[i]; end
    return best;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= N; i++) begin mPend[i] = 0; mSvc[i] = 0; mEn[i] = 0; mPrio[i] = 0; end
      mThr = 0;
    end else begin
      int cid;
      bit oldPend [1:N];
      bit oldSvc [1:N];
      bit oldEn [1:N];
      cid = 0;
      for (int i = 1; i <= N; i++) begin oldPend[i] = mPend[i]; oldSvc[i] = mSvc[i]; oldEn[i] = mEn[i]; end
      if (regRe && regAddr == 0) cid = mBest();
      for (int i = 1; i <= N; i++)
        if (srcIrq[i] && !oldPend[i] && !oldSvc[i]) mPend[i] = 1;
      if (cid != 0) begin mPend[cid] = 0; mSvc[cid] = 1; end
      if (regWe) begin
        if (regAddr == 0) begin
          if (regWdata >= 1 && regWdata <= N && oldEn[regWdata]) mSvc[regWdata] = 0;
        end else if (regAddr == 1) mThr = int'(regWdata[2:0]);
        else if (regAddr == 2) begin
          for (int i = 1; i <= N; i++) mEn[i] = regWdata[i];
        end else if (int'(regAddr) >= 33 && int'(regAddr) <= 32 + N)
          mPrio[int'(regAddr) - 32] = int'(regWdata[2:0]);
      end
    end
  end

  // model comparison every cycle (R3, R4)
  always @(negedge clk) begin
    #1;
    if (!rst && !done) begin
      int exp;
      exp = 0;
      for (int i = 1; i <= N; i++) if (mPend[i] && mEn[i] && mPrio[i] > mThr) exp = 1;
      checks++;
      if (targetIrq !== exp[0]) begin
        errors++;
        $display("FAIL R3 model irq actual %0b expected %0d", targetIrq, exp);
      end
      if (regRe && regAddr == 0) begin
        checks++;
        if (regRdata !== mBest()) begin
          errors++;
          $display("FAIL R4 model claim actual %0d expected %0d", regRdata, mBest());
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge clk);
    regRe = 1; regAddr = AW'(addr);
    #1 data = int'(regRdata);
    @(posedge clk); #1;
    regRe = 0;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWe = 1; regAddr = AW'(addr); regWdata = data;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic claimExp(input string req, input int exp);
    int v;
    rd(0, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic irqExp(input string req, input int exp);
    @(negedge clk); #1;
    chk(req, int'(targetIrq), exp);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    irqExp("R1 irq after reset", 0);
    claimExp("R1 claim after reset", 0);
    rd(1, v); chk("R1 threshold reset", v, 0);
    rd(2, v); chk("R1 enable reset", v, 0);
    rd(35, v); chk("R1 priority reset", v, 0);

    wr(35, 5); wr(37, 5); wr(34, 2); wr(39, 0);
    wr(1, 1);
    wr(2, 32'hAC);
    rd(37, v); chk("R9 priority readback", v, 5);
    rd(2, v); chk("R9 enable readback", v, 32'hAC);
    @(negedge clk);
    srcIrq[2] = 1; srcIrq[3] = 1; srcIrq[5] = 1; srcIrq[7] = 1;
    idle(1);
    irqExp("R2 R3 irq raised by pending", 1);
    claimExp("R4 tie goes to lowest id", 3);
    claimExp("R4 R5 next claim", 5);
    claimExp("R4 lower priority claim", 2);
    claimExp("R10 priority zero never claimed", 0);
    irqExp("R10 irq low with only priority zero pending", 0);

    @(negedge clk); srcIrq[2] = 0;
    wr(0, 5);
    idle(1);
    claimExp("R6 completion out of claim order re-pends", 5);
    wr(0, 2);
    idle(2);
    claimExp("R6 low line not re-pended", 0);

    wr(0, 0);
    wr(0, 259);
    wr(0, 11);
    idle(2);
    claimExp("R8 invalid completion ids ignored", 0);

    wr(2, 32'hA4);
    wr(0, 3);
    wr(2, 32'hAC);
    idle(2);
    claimExp("R7 dropped completion keeps source stuck", 0);
    irqExp("R7 irq stays low while stuck", 0);
    wr(0, 3);
    idle(1);
    claimExp("R7 accepted completion releases source", 3);

    wr(0, 5);
    idle(1);
    irqExp("R6 pending again after completion", 1);
    wr(1, 5);
    irqExp("R3 equal to threshold not signalled", 0);
    claimExp("R3 R5 empty claim", 0);
    wr(1, 1);
    wr(37, 6);
    wr(2, 32'hAC);
    irqExp("R9 pending survives config writes", 1);
    wr(0, 3);
    idle(1);
    claimExp("R4 higher priority beats lower id", 5);
    claimExp("R4 remaining source", 3);
    claimExp("R4 nothing left", 0);
    irqExp("R3 irq low when all in service", 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule